// File: doc/BRIEF.md
# Automatic Serial Transfer Interval Controller

This block is a clocked-serial master. It sends and receives a run of 8-bit bytes without intervention, using a serial clock derived from the system clock. A start strobe begins a run of a given number of bytes. For each byte the block pulls a value from a parallel source and shifts it out most significant bit first. At the same time it samples the serial input into a received byte and presents that byte to a parallel sink.

Between two consecutive bytes the block holds the serial clock high for an inter-byte gap. The gap models the time the processor needs to service each byte. Its length is the largest of three candidates:
- a floor of two and a half serial-clock periods;
- a processor-cycle count picked by a 4-bit activity code;
- when the interval register's mode bit is set, a programmed number of whole serial-clock periods.

Automatic operation runs only when the internal-clock select input is high.

Top module: `auto_serial_ctrl`

## Requirements
- R1: A start strobe is accepted only when the block is idle, `int_clk_sel` is 1 and `byte_count` is not 0. A strobe that fails any of these conditions leaves `busy` low, `sck` high and `tx_take` low. A strobe while busy leaves the run in progress unchanged.
- R2: `sck` idles high. Each bit is `SCK_HALF` system-clock cycles with `sck` low followed by `SCK_HALF` cycles with it high. `so` changes only on the clock edge where `sck` falls. `si` is sampled on the clock edge where `sck` rises.
- R3: Bytes leave on `so` most significant bit first, D7 to D0. `tx_take` pulses for one cycle per byte, and `tx_byte` is taken in that cycle. After the eighth bit, `rx_byte` holds the sampled bits, the first in bit 7, and `rx_valid` pulses for one cycle.
- R4: The inter-byte gap G, in system-clock cycles, is at least max(5·`SCK_HALF`, N·`CPU_DIV`). N is set by `act_code`: 1 (multiply) gives 13, 2 (divide) gives 20, 3 (external access with one wait) gives 9, and any other code gives 7. With `interval_reg[7]` = 0, G equals that maximum and `interval_reg[6:0]` has no effect. `sck` stays high for `SCK_HALF`+G cycles from the rising edge of D0 to the falling edge of the next D7.
- R5: With `interval_reg[7]` = 1, G is the larger of the R4 value and `interval_reg[6:0]`·2·`SCK_HALF`. A programmed value of 0 adds nothing.
- R6: `act_code` and `interval_reg` are sampled once, in the cycle that ends each non-final byte. Changing them during a gap does not alter that gap.
- R7: `busy` rises in the cycle after an accepted start. It stays high until the high phase of the last byte's D0 ends, with no gap after the last byte. `done` pulses for exactly one cycle, in the cycle where `busy` falls.
- R8: While reset is applied (synchronous, active low), `sck`=1, `so`=1, `busy`=0, `done`=0, `rx_valid`=0 and `tx_take`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe for a run |
| byte_count | input | BC_W | Number of bytes in the run |
| int_clk_sel | input | 1 | Selects the internal serial clock; automatic runs need 1 |
| act_code | input | 4 | Processor activity code |
| interval_reg | input | 8 | Bit 7 is the mode; bits 6:0 give the interval in serial-clock periods |
| tx_byte | input | 8 | Byte from the parallel source |
| tx_take | output | 1 | Pulse: `tx_byte` is taken this cycle |
| si | input | 1 | Serial data in |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | Pulse: `rx_byte` is new |
| sck | output | 1 | Serial clock |
| so | output | 1 | Serial data out |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
A wrong gap count or a wrong choice of maximum shows at the ports as a longer or shorter high run on `sck` between bytes. It is visible at the falling edge that starts the next byte, at most a few hundred cycles later. A fault in the shift register or the bit counter shows on `so`, or as a mismatched `rx_byte`, within the same byte, when the serial input is looped back. A fault in the byte counter or the sequencer shows as a wrong number of `rx_valid` pulses, or as a `done` pulse that is not aligned with the fall of `busy`, by the end of the run.

// File: rtl/axfer_pkg.sv
// Package axfer_pkg
// Shared types and helper functions for the automatic serial transfer block.
// Assumes activity codes are 4 bits; unknown codes map to the default cost.
package axfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_GAP  = 2'd3
    } axfer_state_e;

    localparam logic [3:0] ACT_MUL  = 4'h1;
    localparam logic [3:0] ACT_DIV  = 4'h2;
    localparam logic [3:0] ACT_EXTW = 4'h3;

    // Processor-cycle cost of servicing one byte, per activity code.
    function automatic int unsigned cpu_cycles(input logic [3:0] code);
        case (code)
            ACT_MUL:  return 13;
            ACT_DIV:  return 20;
            ACT_EXTW: return 9;
            default:  return 7;
        endcase
    endfunction

    // Larger of two unsigned values.
    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/axfer_gap_calc.sv
// Module axfer_gap_calc
// Purely combinational: computes the inter-byte gap length in system-clock
// cycles as the maximum of the serial-clock floor, the processor cost and
// (in interval mode) the programmed interval. Assumes GAP_W covers the result.
module axfer_gap_calc
    import axfer_pkg::*;
#(
    parameter int unsigned SCK_HALF = 2,
    parameter int unsigned CPU_DIV  = 1,
    parameter int unsigned GAP_W    = 10
) (
    input  logic [3:0]       act_code,
    input  logic [7:0]       interval_reg,
    output logic [GAP_W-1:0] gap_len
);

    localparam int unsigned FLOOR_CYC = 5 * SCK_HALF;
    localparam int unsigned PERIOD    = 2 * SCK_HALF;

    logic [GAP_W-1:0] cpu_term;
    logic [GAP_W-1:0] prog_term;
    logic [GAP_W-1:0] base_term;

    // Processor cost: the multiplier is skipped when the CPU clock equals the system clock.
    generate
        if (CPU_DIV == 1) begin : g_cpu_direct
            always_comb cpu_term = GAP_W'(cpu_cycles(act_code));
        end else begin : g_cpu_scaled
            always_comb cpu_term = GAP_W'(cpu_cycles(act_code) * CPU_DIV);
        end
    endgenerate

    // Programmed interval in whole serial periods, only in interval mode.
    always_comb begin
        if (interval_reg[7])
            prog_term = GAP_W'(interval_reg[6:0]) * GAP_W'(PERIOD);
        else
            prog_term = '0;
    end

    // Maximum of the three candidates.
    always_comb begin
        base_term = (cpu_term > GAP_W'(FLOOR_CYC)) ? cpu_term : GAP_W'(FLOOR_CYC);
        gap_len   = (prog_term > base_term) ? prog_term : base_term;
    end

endmodule

// File: rtl/axfer_seq.sv
// Module axfer_seq
// Sequencer: runs the idle / sck-low / sck-high / gap states, counts bit
// phases, bits and remaining bytes, and issues shift, load and end pulses.
// Assumes SCK_HALF >= 1 and gap_len >= 1 whenever a gap is loaded.
module axfer_seq
    import axfer_pkg::*;
#(
    parameter int unsigned SCK_HALF = 2,
    parameter int unsigned GAP_W    = 10,
    parameter int unsigned BC_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             int_clk_sel,
    input  logic [BC_W-1:0]  byte_count,
    input  logic [GAP_W-1:0] gap_len,
    output logic             sck,
    output logic             busy,
    output logic             done,
    output logic             tx_take,
    output logic             shift_en,
    output logic             fall_upd,
    output logic             byte_end
);

    localparam logic [GAP_W-1:0] HALF_LOAD = GAP_W'(SCK_HALF - 1);

    axfer_state_e     state_q, state_n;
    logic [GAP_W-1:0] cnt_q;
    logic [2:0]       bit_q;
    logic [BC_W-1:0]  remain_q;
    logic             sck_q;
    logic             done_q;

    logic cnt_zero, accept, end_bit, last, gap_done;

    // Event decode from the current state and counters.
    always_comb begin
        cnt_zero = (cnt_q == '0);
        accept   = (state_q == ST_IDLE) && start && int_clk_sel && (byte_count != '0);
        shift_en = (state_q == ST_LOW) && cnt_zero;
        end_bit  = (state_q == ST_HIGH) && cnt_zero;
        byte_end = end_bit && (bit_q == 3'd0);
        fall_upd = end_bit && (bit_q != 3'd0);
        last     = (remain_q == BC_W'(1));
        gap_done = (state_q == ST_GAP) && cnt_zero;
        tx_take  = accept || gap_done;
    end

    // Next-state selection.
    always_comb begin
        state_n = state_q;
        case (state_q)
            ST_IDLE: if (accept)   state_n = ST_LOW;
            ST_LOW:  if (cnt_zero) state_n = ST_HIGH;
            ST_HIGH: if (cnt_zero) state_n = (bit_q != 3'd0) ? ST_LOW :
                                             (last ? ST_IDLE : ST_GAP);
            ST_GAP:  if (cnt_zero) state_n = ST_LOW;
            default: state_n = ST_IDLE;
        endcase
    end

    // State, serial clock and end-of-run pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sck_q   <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            sck_q   <= (state_n != ST_LOW);
            done_q  <= byte_end && last;
        end
    end

    // Phase counter: half periods during bits, gap length between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tx_take || shift_en || fall_upd)
            cnt_q <= HALF_LOAD;
        else if (byte_end && !last)
            cnt_q <= gap_len - GAP_W'(1);
        else if (!cnt_zero)
            cnt_q <= cnt_q - GAP_W'(1);
    end

    // Bit index and remaining-byte counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q    <= 3'd7;
            remain_q <= '0;
        end else begin
            if (tx_take)
                bit_q <= 3'd7;
            else if (fall_upd)
                bit_q <= bit_q - 3'd1;
            if (accept)
                remain_q <= byte_count;
            else if (byte_end)
                remain_q <= remain_q - BC_W'(1);
        end
    end

    assign sck  = sck_q;
    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

    // A run only starts with the internal clock selected.
    assert_start_needs_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(int_clk_sel));

    // The serial clock is high whenever no run is active.
    assert_sck_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck);

    // A freshly loaded gap is never shorter than the 2.5-period floor.
    assert_gap_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && $past(state_q) != ST_GAP) |-> cnt_q >= GAP_W'(5 * SCK_HALF - 1));

    // The end-of-run pulse lasts one cycle and coincides with busy falling.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_with_busy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));

endmodule

// File: rtl/axfer_shifter.sv
// Module axfer_shifter
// Byte shift register: loads a byte, shifts the serial input in on each
// rising phase and updates the output bit on each falling phase. Presents
// the received byte at the end of each byte. Assumes the one-hot control pulses.
module axfer_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       shift_en,
    input  logic       fall_upd,
    input  logic       byte_end,
    input  logic       si,
    output logic       so,
    output logic [7:0] rx_byte,
    output logic       rx_valid
);

    logic [7:0] shift_q;
    logic       so_q;

    // Shift register: load a new byte or move one bit in from si.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shift_q <= '0;
        else if (load)
            shift_q <= load_byte;
        else if (shift_en)
            shift_q <= {shift_q[6:0], si};
    end

    // Output bit: changes only with a load or a falling phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            so_q <= 1'b1;
        else if (load)
            so_q <= load_byte[7];
        else if (fall_upd)
            so_q <= shift_q[7];
    end

    // Received-byte register and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= byte_end;
            if (byte_end)
                rx_byte <= shift_q;
        end
    end

    assign so = so_q;

    // Received strobe is a single-cycle pulse.
    assert_rx_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/auto_serial_ctrl.sv
// Module auto_serial_ctrl
// Top level of the automatic serial transfer controller. Ties the
// sequencer, gap calculator and shift register together. Assumes a single
// clock domain; the serial clock is a registered output of the sequencer.
module auto_serial_ctrl
    import axfer_pkg::*;
#(
    parameter int unsigned SCK_HALF = 2,
    parameter int unsigned CPU_DIV  = 1,
    parameter int unsigned BC_W     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BC_W-1:0] byte_count,
    input  logic            int_clk_sel,
    input  logic [3:0]      act_code,
    input  logic [7:0]      interval_reg,
    input  logic [7:0]      tx_byte,
    output logic            tx_take,
    input  logic            si,
    output logic [7:0]      rx_byte,
    output logic            rx_valid,
    output logic            sck,
    output logic            so,
    output logic            busy,
    output logic            done
);

    localparam int unsigned GAP_MAX = umax(umax(5 * SCK_HALF, 20 * CPU_DIV), 127 * 2 * SCK_HALF);
    localparam int unsigned GAP_W   = $clog2(GAP_MAX + 1);

    logic [GAP_W-1:0] gap_len;
    logic             shift_en, fall_upd, byte_end;

    axfer_gap_calc #(
        .SCK_HALF (SCK_HALF),
        .CPU_DIV  (CPU_DIV),
        .GAP_W    (GAP_W)
    ) u_gap (
        .act_code     (act_code),
        .interval_reg (interval_reg),
        .gap_len      (gap_len)
    );

    axfer_seq #(
        .SCK_HALF (SCK_HALF),
        .GAP_W    (GAP_W),
        .BC_W     (BC_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .int_clk_sel (int_clk_sel),
        .byte_count  (byte_count),
        .gap_len     (gap_len),
        .sck         (sck),
        .busy        (busy),
        .done        (done),
        .tx_take     (tx_take),
        .shift_en    (shift_en),
        .fall_upd    (fall_upd),
        .byte_end    (byte_end)
    );

    axfer_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_take),
        .load_byte (tx_byte),
        .shift_en  (shift_en),
        .fall_upd  (fall_upd),
        .byte_end  (byte_end),
        .si        (si),
        .so        (so),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid)
    );

    // Serial data holds steady while the serial clock stays high.
    assert_so_quiet_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(so));

    // Every byte taken from the source happens inside or at the start of a run.
    assert_take_starts_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> busy);

endmodule

// File: tb/tb_auto_serial_ctrl.sv
module tb_auto_serial_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 2;
    localparam int NVEC       = 12;

    // {act_code[3:0], interval_reg[7:0], expected gap[15:0]}
    localparam logic [27:0] VEC [NVEC] = '{
        {4'h0, 8'h00, 16'd10}, {4'h1, 8'h00, 16'd13}, {4'h2, 8'h00, 16'd20},
        {4'h3, 8'h00, 16'd10}, {4'h7, 8'h00, 16'd10}, {4'hF, 8'h00, 16'd10},
        {4'h2, 8'h7F, 16'd20}, {4'h1, 8'h80, 16'd13}, {4'h0, 8'h83, 16'd12},
        {4'h2, 8'h85, 16'd20}, {4'h2, 8'h86, 16'd24}, {4'h0, 8'hFF, 16'd508}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] byte_count = 8'd2;
    logic       int_clk_sel = 1'b1;
    logic [3:0] act_code = 4'h0;
    logic [7:0] interval_reg = 8'h00;
    logic [7:0] tx_byte;
    logic       tx_take, rx_valid, sck, so, busy, done;
    logic [7:0] rx_byte;

    int checks = 0;
    int fails  = 0;

    logic [7:0] tx_idx = 8'd0;
    logic [7:0] rx_idx = 8'd0;
    logic [7:0] first_tx;

    int run, max_run, rise_cnt, rx_cnt, rx_err, done_cnt, done_bad, so_bad;
    logic [7:0] first_log;
    logic sck_prev = 1'b1;
    logic so_prev  = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input logic [7:0] i);
        return (i * 8'h3B) ^ 8'hA5;
    endfunction

    assign tx_byte = pat(tx_idx);

    auto_serial_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .int_clk_sel(int_clk_sel), .act_code(act_code), .interval_reg(interval_reg),
        .tx_byte(tx_byte), .tx_take(tx_take), .si(so), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .sck(sck), .so(so), .busy(busy), .done(done)
    );

    always @(posedge clk) if (tx_take) tx_idx <= tx_idx + 8'd1;

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (tx_take && !busy) begin
            run = 0; max_run = 0; rise_cnt = 0; rx_cnt = 0; rx_err = 0;
            done_cnt = 0; done_bad = 0; so_bad = 0; first_tx = tx_byte;
        end
        if (sck && !sck_prev && busy) begin
            run = 1;
            if (rise_cnt < 8) first_log = {first_log[6:0], so};
            rise_cnt++;
        end else if (sck && busy) begin
            run++;
        end
        if (!sck && sck_prev && run > max_run) max_run = run;
        if (sck && sck_prev && so != so_prev) so_bad++;
        if (rx_valid) begin
            if (rx_byte != pat(rx_idx)) rx_err++;
            rx_idx = rx_idx + 8'd1;
            rx_cnt++;
        end
        if (done) begin
            done_cnt++;
            if (busy) done_bad++;
        end
        sck_prev = sck;
        so_prev  = so;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        @(negedge clk); #1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 sck", sck, 1); check("R8 so", so, 1); check("R8 busy", busy, 0);
        check("R8 done", done, 0); check("R8 rx_valid", rx_valid, 0); check("R8 tx_take", tx_take, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 and R5: gap rule across codes and modes
        for (int i = 0; i < NVEC; i++) begin
            act_code = VEC[i][27:24]; interval_reg = VEC[i][23:16]; byte_count = 8'd2;
            pulse_start();
            wait_done();
            check(VEC[i][23] ? "R5 gap" : "R4 gap", max_run, H + int'(VEC[i][15:0]));
            check("R3 loopback", rx_err, 0);
            check("R2 so stable high", so_bad, 0);
        end

        // R3: MSB first on so, bytes counted, R7 single done with busy falling
        act_code = 4'h0; interval_reg = 8'h00; byte_count = 8'd3;
        pulse_start();
        wait_done();
        check("R3 msb first", first_log, first_tx);
        check("R3 rx count", rx_cnt, 3);
        check("R7 done pulses", done_cnt, 1);
        check("R7 done with busy low", done_bad, 0);
        check("R7 busy after done", busy, 0);

        // R1: start ignored with internal clock deselected, or zero count
        int_clk_sel = 1'b0; byte_count = 8'd2;
        begin
            int seen = 0;
            pulse_start();
            repeat (20) begin @(negedge clk); if (busy || !sck || tx_take) seen++; end
            check("R1 sel low ignored", seen, 0);
            int_clk_sel = 1'b1; byte_count = 8'd0; seen = 0;
            pulse_start();
            repeat (20) begin @(negedge clk); if (busy || !sck || tx_take) seen++; end
            check("R1 zero count ignored", seen, 0);
        end

        // R1: start during a run does not extend it
        byte_count = 8'd2;
        pulse_start();
        repeat (10) @(negedge clk);
        byte_count = 8'd5;
        pulse_start();
        wait_done();
        check("R1 restart while busy", rx_cnt, 2);

        // R6: code change during the first byte is used; change during the gap is not
        act_code = 4'h0; byte_count = 8'd2;
        pulse_start();
        repeat (6) @(negedge clk);
        act_code = 4'h2;
        wait_done();
        check("R6 sampled at byte end", max_run, H + 20);

        act_code = 4'h2; interval_reg = 8'h00;
        pulse_start();
        while (rise_cnt < 8) @(negedge clk);
        repeat (H + 2) @(negedge clk);
        act_code = 4'h0; interval_reg = 8'hFF;
        wait_done();
        check("R6 gap unchanged", max_run, H + 20);

        summary();
    end

endmodule